// File: doc/BRIEF.md
# Two-way predecoded instruction cache

This block is a small two-way set-associative store for instruction words. Each block holds exactly one instruction, tagged by its full word address. The word is stored alongside a vector of predecode flags and a memory-access flag that an upstream decoder has already computed. A fetch unit presents an address on the lookup port. One cycle later it gets hit or miss, the way that matched, and the stored word and flags. On a miss, the refill path writes the word on the fill port. That write lands in the way that already holds the address when there is one, and otherwise in the way named by the set's single replacement bit.

Every way entry carries a valid bit, so a cleared or never-written entry can never produce a hit. A one-cycle clear request empties the whole structure and resets all replacement bits. Lookups, fills and clears may all be presented in the same cycle. The ordering rules between them are fixed so that the caller can rely on them.

Top module: `pdic_top`

## Requirements
- R1: After reset every lookup misses. A miss response drives rspHit, rspWay, rspInstr, rspFlags and rspLdst to zero.
- R2: rspValid is high in exactly the cycle after a cycle with lkValid high, and low otherwise.
- R3: The word address is pc[ADDR_W-1:2]. The set index is its low SET_BITS bits, so pc[SET_BITS+1:2] selects the set. pc[1:0] is ignored. A hit needs the whole word address to match, so two addresses that share a set but differ above the index bits never hit each other's entry.
- R4: A hit returns the word, flags and memory-access flag last written for that address, and rspWay gives the way that holds it (0 or 1).
- R5: A lookup hit in way 0 sets the set's replacement bit to 1, and a hit in way 1 sets it to 0.
- R6: A fill whose address is already present rewrites that way in place. It sets the replacement bit as a hit in that way would.
- R7: A fill whose address is absent writes the way named by the set's replacement bit (0 means way 0) and leaves that bit unchanged.
- R8: The stored memory-access flag is fillLdst AND NOT fillFlags[0] AND NOT fillFlags[1]. Bit 0 marks a delayed control transfer and bit 1 marks a done/retry instruction.
- R9: A clear request invalidates every entry and zeroes every replacement bit. A fill presented in the same cycle is dropped.
- R10: A lookup sees the state from before any fill or clear in the same cycle. When a lookup hit and a fill hit update the same set's replacement bit in one cycle, the fill's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Invalidate all entries and replacement bits |
| lkValid | input | 1 | Lookup request |
| lkPc | input | ADDR_W | Lookup byte address |
| fillValid | input | 1 | Fill request |
| fillPc | input | ADDR_W | Fill byte address |
| fillInstr | input | INSTR_W | Instruction word to store |
| fillFlags | input | FLAG_W | Predecode flags to store |
| fillLdst | input | 1 | Memory-access flag before forcing |
| rspValid | output | 1 | Lookup response valid |
| rspHit | output | 1 | Lookup hit |
| rspWay | output | 1 | Way that hit |
| rspInstr | output | INSTR_W | Stored instruction word |
| rspFlags | output | FLAG_W | Stored predecode flags |
| rspLdst | output | 1 | Stored memory-access flag |

## Verification
The risky overlap is a lookup and a fill, or a clear, that land in the same set in the same cycle. In that case the lookup must read the old contents, and both requests may try to write the replacement bit. Directed pairs cause this with the same address, with the same set under a different address, and with a clear alongside a fill. A long random mix draws its tags from a small pool, so conflicts happen often. Each response is judged against a bench model. That model reads before it writes and applies replacement-bit writes in the order lookup, then fill, then clear.

// File: rtl/pdic_pkg.sv
`timescale 1ns/1ps
package pdic_pkg;

  // predecode flag positions that the datapath decodes
  localparam int DCTI_BIT       = 0;
  localparam int DONE_RETRY_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic fillWr;
    logic fillWay;
    logic fillLruWr;
    logic fillLruVal;
    logic lkLruWr;
    logic lkLruVal;
    logic lkCapture;
    logic lkHit;
    logic lkWay;
  } pdicStrobes_t;

endpackage

// File: rtl/pdic_way.sv
`timescale 1ns/1ps
module pdic_way #(
  parameter int SET_BITS = 8,
  parameter int TAG_W    = 30,
  parameter int INSTR_W  = 32,
  parameter int FLAG_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearAll,
  input  logic               wrEn,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic [INSTR_W-1:0] wrInstr,
  input  logic [FLAG_W-1:0]  wrFlags,
  input  logic               wrLdst,
  input  logic [TAG_W-1:0]   lkTag,
  output logic               lkMatch,
  output logic [INSTR_W-1:0] lkInstr,
  output logic [FLAG_W-1:0]  lkFlags,
  output logic               lkLdst,
  output logic               fillMatch
);

  localparam int SETS = 1 << SET_BITS;

  logic [SET_BITS-1:0] lkIdx;
  logic [SET_BITS-1:0] fillIdx;
  logic [SETS-1:0]     validQ;
  logic [SETS-1:0]     ldstMem;
  logic [TAG_W-1:0]    tagMem   [SETS];
  logic [INSTR_W-1:0]  instrMem [SETS];
  logic [FLAG_W-1:0]   flagMem  [SETS];

  assign lkIdx   = lkTag[SET_BITS-1:0];
  assign fillIdx = fillTag[SET_BITS-1:0];

  // valid bits: reset and clear act on the whole way in one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (clearAll) begin
      validQ <= '0;
    end else if (wrEn) begin
      validQ[fillIdx] <= 1'b1;
    end
  end

  // payload storage, no reset needed behind the valid bits
  always_ff @(posedge clk) begin
    if (wrEn) begin
      tagMem[fillIdx]   <= fillTag;
      instrMem[fillIdx] <= wrInstr;
      flagMem[fillIdx]  <= wrFlags;
      ldstMem[fillIdx]  <= wrLdst;
    end
  end

  assign lkMatch   = validQ[lkIdx] && (tagMem[lkIdx] == lkTag);
  assign lkInstr   = instrMem[lkIdx];
  assign lkFlags   = flagMem[lkIdx];
  assign lkLdst    = ldstMem[lkIdx];
  assign fillMatch = validQ[fillIdx] && (tagMem[fillIdx] == fillTag);

endmodule

// File: rtl/pdic_datapath.sv
`timescale 1ns/1ps
module pdic_datapath
  import pdic_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 8,
  parameter int INSTR_W  = 32,
  parameter int FLAG_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pdicStrobes_t       st,
  input  logic [ADDR_W-1:0]  lkPc,
  input  logic [ADDR_W-1:0]  fillPc,
  input  logic [INSTR_W-1:0] fillInstr,
  input  logic [FLAG_W-1:0]  fillFlags,
  input  logic               fillLdst,
  output logic [1:0]         lkHitVec,
  output logic [1:0]         fillHitVec,
  output logic               fillLruBit,
  output logic               rspValid,
  output logic               rspHit,
  output logic               rspWay,
  output logic [INSTR_W-1:0] rspInstr,
  output logic [FLAG_W-1:0]  rspFlags,
  output logic               rspLdst
);

  localparam int TAG_W = ADDR_W - 2;
  localparam int SETS  = 1 << SET_BITS;

  logic [TAG_W-1:0]    lkTag;
  logic [TAG_W-1:0]    fillTag;
  logic [SET_BITS-1:0] lkIdx;
  logic [SET_BITS-1:0] fillIdx;
  logic                storeLdst;
  logic                unusedLowBits;
  logic [SETS-1:0]     lruQ;

  logic [INSTR_W-1:0]  wayInstr [2];
  logic [FLAG_W-1:0]   wayFlags [2];
  logic [1:0]          wayLdst;

  assign lkTag         = lkPc[ADDR_W-1:2];
  assign fillTag       = fillPc[ADDR_W-1:2];
  assign lkIdx         = lkTag[SET_BITS-1:0];
  assign fillIdx       = fillTag[SET_BITS-1:0];
  assign unusedLowBits = ^{lkPc[1:0], fillPc[1:0]};

  // memory-access flag is meaningless for control transfers
  assign storeLdst = fillLdst & ~fillFlags[DCTI_BIT] & ~fillFlags[DONE_RETRY_BIT];

  for (genvar w = 0; w < 2; w++) begin : g_way
    pdic_way #(
      .SET_BITS(SET_BITS),
      .TAG_W   (TAG_W),
      .INSTR_W (INSTR_W),
      .FLAG_W  (FLAG_W)
    ) u_way (
      .clk      (clk),
      .rstN     (rstN),
      .clearAll (st.clearAll),
      .wrEn     (st.fillWr && (st.fillWay == 1'(w))),
      .fillTag  (fillTag),
      .wrInstr  (fillInstr),
      .wrFlags  (fillFlags),
      .wrLdst   (storeLdst),
      .lkTag    (lkTag),
      .lkMatch  (lkHitVec[w]),
      .lkInstr  (wayInstr[w]),
      .lkFlags  (wayFlags[w]),
      .lkLdst   (wayLdst[w]),
      .fillMatch(fillHitVec[w])
    );
  end

  // replacement bits: the fill write is placed last so it wins on a shared set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lruQ <= '0;
    end else if (st.clearAll) begin
      lruQ <= '0;
    end else begin
      if (st.lkLruWr) begin
        lruQ[lkIdx] <= st.lkLruVal;
      end
      if (st.fillLruWr) begin
        lruQ[fillIdx] <= st.fillLruVal;
      end
    end
  end

  assign fillLruBit = lruQ[fillIdx];

  // response register, one cycle after the request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspWay   <= 1'b0;
      rspInstr <= '0;
      rspFlags <= '0;
      rspLdst  <= 1'b0;
    end else begin
      rspValid <= st.lkCapture;
      if (st.lkHit) begin
        rspHit   <= 1'b1;
        rspWay   <= st.lkWay;
        rspInstr <= wayInstr[st.lkWay];
        rspFlags <= wayFlags[st.lkWay];
        rspLdst  <= wayLdst[st.lkWay];
      end else begin
        rspHit   <= 1'b0;
        rspWay   <= 1'b0;
        rspInstr <= '0;
        rspFlags <= '0;
        rspLdst  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pdic_control.sv
`timescale 1ns/1ps
module pdic_control
  import pdic_pkg::*;
(
  input  logic         clearReq,
  input  logic         lkValid,
  input  logic         fillValid,
  input  logic [1:0]   lkHitVec,
  input  logic [1:0]   fillHitVec,
  input  logic         fillLruBit,
  output pdicStrobes_t st
);

  logic lkAny;
  logic fillAny;
  logic fillWayPick;

  assign lkAny   = lkValid && (lkHitVec != 2'b00);
  assign fillAny = fillHitVec != 2'b00;

  // way 0 is examined first; a miss falls back to the replacement bit
  always_comb begin
    if (fillHitVec[0]) begin
      fillWayPick = 1'b0;
    end else if (fillHitVec[1]) begin
      fillWayPick = 1'b1;
    end else begin
      fillWayPick = fillLruBit;
    end
  end

  always_comb begin
    st            = '0;
    st.clearAll   = clearReq;
    st.lkCapture  = lkValid;
    st.lkHit      = lkAny;
    st.lkWay      = lkAny && !lkHitVec[0];
    st.lkLruWr    = lkAny && !clearReq;
    st.lkLruVal   = lkHitVec[0];
    st.fillWr     = fillValid && !clearReq;
    st.fillWay    = fillWayPick;
    st.fillLruWr  = fillValid && !clearReq && fillAny;
    st.fillLruVal = !fillWayPick;
  end

endmodule

// File: rtl/pdic_top.sv
`timescale 1ns/1ps
module pdic_top
  import pdic_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 8,
  parameter int INSTR_W  = 32,
  parameter int FLAG_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearReq,
  input  logic               lkValid,
  input  logic [ADDR_W-1:0]  lkPc,
  input  logic               fillValid,
  input  logic [ADDR_W-1:0]  fillPc,
  input  logic [INSTR_W-1:0] fillInstr,
  input  logic [FLAG_W-1:0]  fillFlags,
  input  logic               fillLdst,
  output logic               rspValid,
  output logic               rspHit,
  output logic               rspWay,
  output logic [INSTR_W-1:0] rspInstr,
  output logic [FLAG_W-1:0]  rspFlags,
  output logic               rspLdst
);

  pdicStrobes_t strobes;
  logic [1:0]   lkHitVec;
  logic [1:0]   fillHitVec;
  logic         fillLruBit;

  pdic_control u_ctrl (
    .clearReq  (clearReq),
    .lkValid   (lkValid),
    .fillValid (fillValid),
    .lkHitVec  (lkHitVec),
    .fillHitVec(fillHitVec),
    .fillLruBit(fillLruBit),
    .st        (strobes)
  );

  pdic_datapath #(
    .ADDR_W  (ADDR_W),
    .SET_BITS(SET_BITS),
    .INSTR_W (INSTR_W),
    .FLAG_W  (FLAG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .lkPc      (lkPc),
    .fillPc    (fillPc),
    .fillInstr (fillInstr),
    .fillFlags (fillFlags),
    .fillLdst  (fillLdst),
    .lkHitVec  (lkHitVec),
    .fillHitVec(fillHitVec),
    .fillLruBit(fillLruBit),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspWay    (rspWay),
    .rspInstr  (rspInstr),
    .rspFlags  (rspFlags),
    .rspLdst   (rspLdst)
  );

endmodule

// File: rtl/pdic_checker.sv
`timescale 1ns/1ps
module pdic_checker #(
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int FLAG_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               clearReq,
  input logic               lkValid,
  input logic [ADDR_W-1:0]  lkPc,
  input logic               fillValid,
  input logic [ADDR_W-1:0]  fillPc,
  input logic [INSTR_W-1:0] fillInstr,
  input logic               rspValid,
  input logic               rspHit,
  input logic               rspWay,
  input logic [INSTR_W-1:0] rspInstr,
  input logic [FLAG_W-1:0]  rspFlags,
  input logic               rspLdst
);

  logic unusedLow;
  assign unusedLow = ^{lkPc[1:0], fillPc[1:0]};

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);

  a_r1_miss_is_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspInstr == '0 && rspFlags == '0 && !rspLdst && !rspWay));

  a_r8_ldst_forced: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && (rspFlags[0] || rspFlags[1])) |-> !rspLdst);

  a_r9_clear_then_miss: assert property (@(posedge clk) disable iff (!rstN)
    clearReq ##1 lkValid |=> !rspHit);

  a_r6_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !clearReq) ##1 (lkValid && lkPc[ADDR_W-1:2] == $past(fillPc[ADDR_W-1:2]))
    |=> (rspHit && rspInstr == $past(fillInstr, 2)));

endmodule

bind pdic_top pdic_checker #(
  .ADDR_W (ADDR_W),
  .INSTR_W(INSTR_W),
  .FLAG_W (FLAG_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clearReq (clearReq),
  .lkValid  (lkValid),
  .lkPc     (lkPc),
  .fillValid(fillValid),
  .fillPc   (fillPc),
  .fillInstr(fillInstr),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspWay   (rspWay),
  .rspInstr (rspInstr),
  .rspFlags (rspFlags),
  .rspLdst  (rspLdst)
);

// File: tb/pdic_top_tb_top.sv
`timescale 1ns/1ps
module pdic_top_tb_top;

  localparam int AW   = 12;
  localparam int SB   = 3;
  localparam int IW   = 32;
  localparam int FW   = 8;
  localparam int NSET = 1 << SB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clearReq = 1'b0;
  logic          lkValid = 1'b0;
  logic [AW-1:0] lkPc = '0;
  logic          fillValid = 1'b0;
  logic [AW-1:0] fillPc = '0;
  logic [IW-1:0] fillInstr = '0;
  logic [FW-1:0] fillFlags = '0;
  logic          fillLdst = 1'b0;
  logic          rspValid, rspHit, rspWay, rspLdst;
  logic [IW-1:0] rspInstr;
  logic [FW-1:0] rspFlags;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  // bench model of the cache state
  logic [AW-3:0] mTag   [2][NSET];
  bit            mValid [2][NSET];
  logic [IW-1:0] mInstr [2][NSET];
  logic [FW-1:0] mFlags [2][NSET];
  bit            mLdst  [2][NSET];
  bit            mLru   [NSET];

  always #4 clk = ~clk;  // 125 MHz

  pdic_top #(.ADDR_W(AW), .SET_BITS(SB), .INSTR_W(IW), .FLAG_W(FW)) dut_i (
    .clk(clk), .rstN(rstN), .clearReq(clearReq),
    .lkValid(lkValid), .lkPc(lkPc),
    .fillValid(fillValid), .fillPc(fillPc), .fillInstr(fillInstr),
    .fillFlags(fillFlags), .fillLdst(fillLdst),
    .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay),
    .rspInstr(rspInstr), .rspFlags(rspFlags), .rspLdst(rspLdst)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkPc(input int k, input int s, input int low);
    return {7'(k), 3'(s), 2'(low)};
  endfunction

  task automatic step(input bit doLk, input logic [AW-1:0] lpc,
                      input bit doFill, input logic [AW-1:0] fpc,
                      input logic [IW-1:0] fins, input logic [FW-1:0] ffl, input bit fld,
                      input bit doClr, input string req);
    logic [AW-3:0] lt, ft;
    int li, fi;
    bit eHit, eWay, fMatch, fWay, preLru;
    logic [IW-1:0] eInstr;
    logic [FW-1:0] eFlags;
    bit eLdst;
    logic [42:0] expV, actV;
    @(negedge clk);
    lkValid = doLk; lkPc = lpc; fillValid = doFill; fillPc = fpc;
    fillInstr = fins; fillFlags = ffl; fillLdst = fld; clearReq = doClr;
    lt = lpc[AW-1:2]; li = int'(lt[SB-1:0]);
    ft = fpc[AW-1:2]; fi = int'(ft[SB-1:0]);
    eHit = 0; eWay = 0; eInstr = '0; eFlags = '0; eLdst = 0;
    if (doLk) begin
      if (mValid[0][li] && mTag[0][li] == lt) begin eHit = 1; eWay = 0; end
      else if (mValid[1][li] && mTag[1][li] == lt) begin eHit = 1; eWay = 1; end
      if (eHit) begin eInstr = mInstr[eWay][li]; eFlags = mFlags[eWay][li]; eLdst = mLdst[eWay][li]; end
    end
    fMatch = 0; preLru = mLru[fi]; fWay = preLru;
    if (mValid[0][fi] && mTag[0][fi] == ft) begin fMatch = 1; fWay = 0; end
    else if (mValid[1][fi] && mTag[1][fi] == ft) begin fMatch = 1; fWay = 1; end
    @(posedge clk);
    #1;
    check(rspValid == doLk, {req, " rspValid"}, 64'(rspValid), 64'(doLk));
    if (doLk) begin
      expV = {eHit, eWay, eInstr, eFlags, eLdst};
      actV = {rspHit, rspWay, rspInstr, rspFlags, rspLdst};
      check(actV == expV, {req, " response"}, 64'(actV), 64'(expV));
    end
    // model update: lookup, then fill, then clear
    if (doClr) begin
      for (int s = 0; s < NSET; s++) begin
        mValid[0][s] = 0; mValid[1][s] = 0; mLru[s] = 0;
      end
    end else begin
      if (doLk && eHit) mLru[li] = (eWay == 0);
      if (doFill) begin
        mValid[fWay][fi] = 1; mTag[fWay][fi] = ft; mInstr[fWay][fi] = fins;
        mFlags[fWay][fi] = ffl; mLdst[fWay][fi] = fld & ~ffl[0] & ~ffl[1];
        if (fMatch) mLru[fi] = (fWay == 0);
      end
    end
  endtask

  task automatic lookup(input logic [AW-1:0] pc, input string req);
    step(1, pc, 0, '0, '0, '0, 0, 0, req);
  endtask

  task automatic fill(input logic [AW-1:0] pc, input logic [IW-1:0] ins, input logic [FW-1:0] fl,
                      input bit ld, input string req);
    step(0, '0, 1, pc, ins, fl, ld, 0, req);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycleCount);
      finish();
    end
  end

  initial begin
    for (int s = 0; s < NSET; s++) begin
      mLru[s] = 0;
      for (int w = 0; w < 2; w++) begin
        mValid[w][s] = 0; mTag[w][s] = '0; mInstr[w][s] = '0; mFlags[w][s] = '0; mLdst[w][s] = 0;
      end
    end
    repeat (3) @(posedge clk);
    #1;
    check(rspValid == 0 && rspHit == 0, "R1 reset outputs", 64'({rspValid, rspHit}), 64'(0));
    @(negedge clk);
    rstN = 1;

    // R1: everything misses after reset; R2 idle cycle gives no response
    for (int s = 0; s < NSET; s++) lookup(mkPc(s + 1, s, s & 3), "R1");
    step(0, '0, 0, '0, '0, '0, 0, 0, "R2 idle");

    // R3 R4 R5 R7 R8 over every set
    for (int s = 0; s < NSET; s++) begin
      fill(mkPc(1, s, 0), 32'hA100_0000 + 32'(s), 8'(s), 1, "R7 first fill way0");
      lookup(mkPc(1, s, 0), "R4 R8 hit way0");
      fill(mkPc(2, s, 0), 32'hA200_0000 + 32'(s), 8'(s + 1), 1, "R7 victim after R5");
      lookup(mkPc(2, s, 1), "R4 hit way1");
      lookup(mkPc(1, s, 3), "R3 low bits ignored");
      fill(mkPc(3, s, 0), 32'hA300_0000 + 32'(s), 8'(s + 2), 1, "R7 replace way1");
      lookup(mkPc(2, s, 0), "R3 full tag miss");
      lookup(mkPc(3, s, 2), "R5 hit way1");
      fill(mkPc(4, s, 0), 32'hA400_0000 + 32'(s), 8'(s + 3), 1, "R7 replace way0");
      lookup(mkPc(1, s, 0), "R5 evicted");
      lookup(mkPc(4, s, 0), "R4 R8 new way0");
      fill(mkPc(4, s, 1), 32'hB400_0000 + 32'(s), 8'(s), 1, "R6 rewrite in place");
      lookup(mkPc(4, s, 0), "R6 rewritten data");
      fill(mkPc(5, s, 0), 32'hA500_0000 + 32'(s), 8'h3, 1, "R6 lru after match");
      lookup(mkPc(3, s, 0), "R6 victim chosen");
      lookup(mkPc(5, s, 0), "R8 flags force ldst");
    end

    // R10: same-cycle lookup and fill to one address, then check
    step(1, mkPc(9, 0, 0), 1, mkPc(9, 0, 0), 32'hC900_0000, 8'h0, 1, 0, "R10 read before fill");
    lookup(mkPc(9, 0, 0), "R10 fill visible next");
    // R10: lookup hit and matching fill in one set, fill lru wins
    step(1, mkPc(9, 0, 0), 1, mkPc(5, 0, 0), 32'hC500_0000, 8'h0, 0, 0, "R10 both hit");
    fill(mkPc(10, 0, 0), 32'hCA00_0000, 8'h0, 0, "R10 victim after shared lru");
    lookup(mkPc(9, 0, 0), "R10 resulting state");
    lookup(mkPc(5, 0, 0), "R10 resulting state");

    // R9: clear with a lookup and a fill in the same cycle
    step(1, mkPc(9, 0, 0), 1, mkPc(11, 1, 0), 32'hCB00_0000, 8'h0, 1, 1, "R9 R10 clear cycle");
    for (int s = 0; s < NSET; s++) lookup(mkPc(5, s, 0), "R9 cleared");
    lookup(mkPc(11, 1, 0), "R9 dropped fill");
    fill(mkPc(12, 2, 0), 32'hCC00_0000, 8'h0, 1, "R9 lru zeroed");
    lookup(mkPc(12, 2, 0), "R9 way0 after clear");

    // random mix on a small tag pool
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], {5'd0, r[7:1]}, r[8], {5'd0, r[15:9]}, $urandom, r[23:16], r[24],
           (r[30:25] == 6'd0), "R10 random mix");
    end

    step(0, '0, 0, '0, '0, '0, 0, 0, "R2 idle end");
    finish();
  end

endmodule